// File: doc/BRIEF.md
# Four-Way Instruction Translation Buffer

This block is a small, fully associative translation buffer for instruction fetch. It holds four entries and resolves a virtual address against all of them at once. A match needs three things: the virtual page under the entry's own page-size mask, the address-space identifier (which the entry's shared flag or the requester can waive), and a set valid flag. A single match completes with a physical address. Two or more matches report a multi-hit. When nothing matches, the block asks a larger unified translation buffer for help. It waits for that buffer's answer and, on a hit, installs the returned entry in the slot that a six-bit pairwise recency state names as least recently used.

Software can also reach the entries directly through two arrays: an address array (page, identifier, valid) and a data array (physical page, flags). Address bits 8:7 pick the entry. The control is a four-state machine. In `ST_IDLE` the block waits for a request. Taking `lk_req` moves it to `ST_SEARCH`, which compares the latched address. `ST_SEARCH` goes to `ST_DONE` on a hit or a multi-hit and to `ST_REFILL` on a miss. `ST_REFILL` asserts `ut_req` until `ut_rsp_valid` arrives and then goes to `ST_DONE`. `ST_DONE` shows the result for one cycle and returns to `ST_IDLE`.

Top module: `itlb4`

## Requirements
- R1: After reset all four entries read back as all zeros with the valid flag (bit 8) clear. `lk_done`, `lk_busy` and `ut_req` are low, and the recency state is zero, so the first refill goes to entry 3.
- R2: An entry matches when flag bit 8 (valid) is set, the identifier test passes and the virtual page agrees with the address bits 31:10 under the page mask. The page-size code is {flag bit 7, flag bit 4}: 00 gives 1 KB, 01 gives 4 KB, 10 gives 64 KB and 11 gives 1 MB. A single match returns `lk_result`=01 (hit), the entry number, the entry's flags and a physical address. Above the page size that address takes the entry's physical page; below it, it takes the virtual address.
- R3: The identifier test passes when `lk_asid_chk` is 0, when the entry's shared flag (bit 1) is set, or when the entry identifier equals `lk_asid`.
- R4: A hit or an install on entry k updates the recency state L as follows. Entry 0 gives L&0x07. Entry 1 gives (L&0x19)|0x20. Entry 2 gives (L&0x3E)|0x14. Entry 3 gives L|0x0B.
- R5: Two or more matching entries give `lk_result`=11 (multi-hit). There is no refill request, and neither the entries nor the recency state change.
- R6: With no match, `ut_req` rises with `ut_va` equal to the lookup address. It stays high until `ut_rsp_valid`. A response kind of 10 (miss) or 11 (multi-hit) is passed on as the result and leaves the entries unchanged.
- R7: A response kind of 01 (hit) installs the returned entry in the victim slot, with its flags ANDed with 0x1DA, and completes as a hit in that slot. The victim is chosen in priority order: entry 0 if (L&0x38)==0x38; else entry 1 if (L&0x26)==0x06; else entry 2 if (L&0x15)==0x01; else entry 3.
- R8: An address-array write (`ar_sel_data`=0) sets the page from bits 31:10, the valid flag from bit 8 and the identifier from bits 7:0. An address-array read returns {page, 0, valid, identifier}.
- R9: A data-array write (`ar_sel_data`=1) sets the physical page from bits 28:10 and the flags from bits 8:0 ANDed with 0x1DA. A data-array read returns {3'b0, physical page, 0, flags}. Reads are combinational on `ar_addr` and `ar_sel_data`.
- R10: `ar_addr` (address bits 8:7) selects the entry. A write is accepted only in `ST_IDLE`. A write while `lk_busy` is high has no effect.
- R11: `lk_done` is a one-cycle pulse. For a hit or a multi-hit it is high in the second cycle after the cycle in which `lk_req` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Start a lookup (taken in ST_IDLE) |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_asid_chk | input | 1 | 1: compare identifiers; 0: page-only match |
| lk_busy | output | 1 | High outside ST_IDLE |
| lk_done | output | 1 | Result valid for one cycle |
| lk_result | output | 2 | 01 hit, 10 miss, 11 multi-hit |
| lk_slot | output | 2 | Entry that hit or was filled |
| lk_pa | output | 32 | Physical address on a hit |
| lk_flags | output | 9 | Flags of the entry that hit |
| ut_req | output | 1 | Refill request to the unified buffer |
| ut_va | output | 32 | Address sent with the refill request |
| ut_asid_chk | output | 1 | Identifier-compare mode sent with the request |
| ut_rsp_valid | input | 1 | Response from the unified buffer |
| ut_rsp_kind | input | 2 | 01 hit, 10 miss, 11 multi-hit |
| ut_rsp_vpn | input | 22 | Returned virtual page (address bits 31:10) |
| ut_rsp_asid | input | 8 | Returned identifier |
| ut_rsp_ppn | input | 19 | Returned physical page (address bits 28:10) |
| ut_rsp_flags | input | 9 | Returned flags |
| ar_en | input | 1 | Array access strobe |
| ar_we | input | 1 | Array write |
| ar_sel_data | input | 1 | 0 address array, 1 data array |
| ar_addr | input | 2 | Address bits 8:7, entry select |
| ar_wdata | input | 32 | Array write value |
| ar_rdata | output | 32 | Array read value |

## Verification
The bench builds the block with the package defaults: four entries, 8-bit identifiers and 22-bit virtual pages. It draws virtual pages from a pool of only 32 values and identifiers from two values. With these settings, random array writes and refills often produce overlapping entries of different page sizes, so multi-hits, shared-flag matches and masked-offset hits all come up. Because the pool is small, every victim rule is reached many times from both the hit-driven and the refill-driven recency updates.

// File: rtl/itlb4_pkg.sv
package itlb4_pkg;

    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 10;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = 19;
    localparam int ASID_W   = 8;
    localparam int FLG_W    = 9;
    localparam int WAYS     = 4;
    localparam int SLOT_W   = $clog2(WAYS);
    localparam int CNT_W    = $clog2(WAYS + 1);
    localparam int LRU_W    = WAYS * (WAYS - 1) / 2;

    localparam int F_VALID = 8;
    localparam int F_SZHI  = 7;
    localparam int F_SZLO  = 4;
    localparam int F_SHARE = 1;
    localparam logic [FLG_W-1:0] FLAG_KEEP = 9'h1DA;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_HIT   = 2'd1,
        RES_MISS  = 2'd2,
        RES_MULTI = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_REFILL,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [FLG_W-1:0]  flags;
    } ent_t;

    // Page mask over the virtual page bits, from the size code {bit7,bit4}
    function automatic logic [VPN_W-1:0] page_mask(input logic [FLG_W-1:0] f);
        logic [VPN_W-1:0] m;
        unique case ({f[F_SZHI], f[F_SZLO]})
            2'b00: m = '1;
            2'b01: m = {{(VPN_W-2){1'b1}}, 2'b00};
            2'b10: m = {{(VPN_W-6){1'b1}}, 6'b0};
            2'b11: m = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
        return m;
    endfunction

    function automatic logic [VA_W-1:0] pa_form(input ent_t e, input logic [VA_W-1:0] va);
        logic [VPN_W-1:0] m;
        logic [VPN_W-1:0] ext;
        m   = page_mask(e.flags);
        ext = {{(VPN_W-PPN_W){1'b0}}, e.ppn};
        return {(ext & m) | (va[VA_W-1:PG_SHIFT] & ~m), va[PG_SHIFT-1:0]};
    endfunction

    function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] l,
                                                    input logic [SLOT_W-1:0] s);
        logic [LRU_W-1:0] r;
        unique case (s)
            2'd0: r = l & 6'h07;
            2'd1: r = (l & 6'h19) | 6'h20;
            2'd2: r = (l & 6'h3E) | 6'h14;
            2'd3: r = l | 6'h0B;
        endcase
        return r;
    endfunction

    function automatic logic [SLOT_W-1:0] lru_victim(input logic [LRU_W-1:0] l);
        if ((l & 6'h38) == 6'h38)      return 2'd0;
        else if ((l & 6'h26) == 6'h06) return 2'd1;
        else if ((l & 6'h15) == 6'h01) return 2'd2;
        else                           return 2'd3;
    endfunction

endpackage

// File: rtl/itlb4_lru.sv
module itlb4_lru
    import itlb4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch,
    input  logic [SLOT_W-1:0] touch_slot,
    output logic [SLOT_W-1:0] victim
);

    logic [LRU_W-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lru_q <= '0;
        else if (touch) lru_q <= lru_touch(lru_q, touch_slot);
    end

    always_comb victim = lru_victim(lru_q);

    // R4
    touch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && touch_slot == 2'd0) |=> (lru_q[5:3] == 3'b000));

    // R4
    touch3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && touch_slot == 2'd3) |=> (victim != 2'd3));

endmodule

// File: rtl/itlb4_store.sv
module itlb4_store
    import itlb4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_data,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VA_W-1:0]   wr_val,
    input  logic              rf_en,
    input  logic [SLOT_W-1:0] rf_slot,
    input  ent_t              rf_ent,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic              rd_data,
    output logic [VA_W-1:0]   rd_word,
    output ent_t [WAYS-1:0]   ents
);

    ent_t [WAYS-1:0] ents_q;
    logic            unused_bit9;

    assign unused_bit9 = wr_val[9];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            for (int i = 0; i < WAYS; i++) begin
                if (rf_en && rf_slot == SLOT_W'(i)) begin
                    ents_q[i] <= rf_ent;
                end else if (wr_en && wr_slot == SLOT_W'(i)) begin
                    if (!wr_data) begin
                        ents_q[i].vpn            <= wr_val[VA_W-1:PG_SHIFT];
                        ents_q[i].asid           <= wr_val[ASID_W-1:0];
                        ents_q[i].flags[F_VALID] <= wr_val[F_VALID];
                    end else begin
                        ents_q[i].ppn   <= wr_val[PG_SHIFT+PPN_W-1:PG_SHIFT];
                        ents_q[i].flags <= wr_val[FLG_W-1:0] & FLAG_KEEP;
                    end
                end
            end
        end
    end

    assign ents = ents_q;

    always_comb begin
        if (rd_data)
            rd_word = {{(VA_W-PG_SHIFT-PPN_W){1'b0}}, ents_q[rd_slot].ppn, 1'b0,
                       ents_q[rd_slot].flags};
        else
            rd_word = {ents_q[rd_slot].vpn, 1'b0, ents_q[rd_slot].flags[F_VALID],
                       ents_q[rd_slot].asid};
    end

endmodule

// File: rtl/itlb4_cam.sv
module itlb4_cam
    import itlb4_pkg::*;
(
    input  ent_t [WAYS-1:0]   ents,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  logic              asid_chk,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [SLOT_W-1:0] hit_idx
);

    logic [WAYS-1:0] hit;

    for (genvar i = 0; i < WAYS; i++) begin : g_cmp
        logic id_ok;
        logic pg_ok;
        assign id_ok  = !asid_chk || ents[i].flags[F_SHARE] || (ents[i].asid == asid);
        assign pg_ok  = ((ents[i].vpn ^ va[VA_W-1:PG_SHIFT]) & page_mask(ents[i].flags)) == '0;
        assign hit[i] = ents[i].flags[F_VALID] && id_ok && pg_ok;
    end

    always_comb begin
        hit_cnt = '0;
        hit_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                hit_cnt = hit_cnt + CNT_W'(1);
                hit_idx = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/itlb4.sv
module itlb4
    import itlb4_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_req,
    input  logic [31:0] lk_va,
    input  logic [7:0]  lk_asid,
    input  logic        lk_asid_chk,
    output logic        lk_busy,
    output logic        lk_done,
    output logic [1:0]  lk_result,
    output logic [1:0]  lk_slot,
    output logic [31:0] lk_pa,
    output logic [8:0]  lk_flags,
    output logic        ut_req,
    output logic [31:0] ut_va,
    output logic        ut_asid_chk,
    input  logic        ut_rsp_valid,
    input  logic [1:0]  ut_rsp_kind,
    input  logic [21:0] ut_rsp_vpn,
    input  logic [7:0]  ut_rsp_asid,
    input  logic [18:0] ut_rsp_ppn,
    input  logic [8:0]  ut_rsp_flags,
    input  logic        ar_en,
    input  logic        ar_we,
    input  logic        ar_sel_data,
    input  logic [8:7]  ar_addr,
    input  logic [31:0] ar_wdata,
    output logic [31:0] ar_rdata
);

    st_e               state, nxt;
    ent_t [WAYS-1:0]   ents;
    logic [CNT_W-1:0]  hit_cnt;
    logic [SLOT_W-1:0] hit_idx;
    logic [SLOT_W-1:0] victim;
    logic              touch_en;
    logic [SLOT_W-1:0] touch_slot;
    logic              rf_en;
    ent_t              rf_ent;
    logic              ar_wr;

    logic [VA_W-1:0]   q_va;
    logic [ASID_W-1:0] q_asid;
    logic              q_chk;
    res_e              q_res;
    logic [SLOT_W-1:0] q_slot;
    logic [VA_W-1:0]   q_pa;
    logic [FLG_W-1:0]  q_flags;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (lk_req) nxt = ST_SEARCH;
            ST_SEARCH: nxt = (hit_cnt == '0) ? ST_REFILL : ST_DONE;
            ST_REFILL: if (ut_rsp_valid) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
        endcase
    end

    // ---------------- outputs from state ----------------
    always_comb begin
        lk_busy = 1'b1;
        lk_done = 1'b0;
        ut_req  = 1'b0;
        unique case (state)
            ST_IDLE:   lk_busy = 1'b0;
            ST_SEARCH: ;
            ST_REFILL: ut_req  = 1'b1;
            ST_DONE:   lk_done = 1'b1;
        endcase
    end

    // ---------------- datapath ----------------
    assign ar_wr  = ar_en && ar_we && (state == ST_IDLE);
    assign rf_en  = (state == ST_REFILL) && ut_rsp_valid && (ut_rsp_kind == RES_HIT);
    assign rf_ent = '{vpn: ut_rsp_vpn, asid: ut_rsp_asid, ppn: ut_rsp_ppn,
                      flags: ut_rsp_flags & FLAG_KEEP};

    assign touch_en   = ((state == ST_SEARCH) && (hit_cnt == CNT_W'(1))) || rf_en;
    assign touch_slot = (state == ST_SEARCH) ? hit_idx : victim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_va    <= '0;
            q_asid  <= '0;
            q_chk   <= 1'b0;
            q_res   <= RES_NONE;
            q_slot  <= '0;
            q_pa    <= '0;
            q_flags <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (lk_req) begin
                        q_va   <= lk_va;
                        q_asid <= lk_asid;
                        q_chk  <= lk_asid_chk;
                    end
                end
                ST_SEARCH: begin
                    if (hit_cnt == CNT_W'(1)) begin
                        q_res   <= RES_HIT;
                        q_slot  <= hit_idx;
                        q_pa    <= pa_form(ents[hit_idx], q_va);
                        q_flags <= ents[hit_idx].flags;
                    end else if (hit_cnt != '0) begin
                        q_res   <= RES_MULTI;
                        q_pa    <= '0;
                        q_flags <= '0;
                    end
                end
                ST_REFILL: begin
                    if (ut_rsp_valid) begin
                        if (ut_rsp_kind == RES_HIT) begin
                            q_res   <= RES_HIT;
                            q_slot  <= victim;
                            q_pa    <= pa_form(rf_ent, q_va);
                            q_flags <= rf_ent.flags;
                        end else begin
                            q_res   <= (ut_rsp_kind == RES_MULTI) ? RES_MULTI : RES_MISS;
                            q_pa    <= '0;
                            q_flags <= '0;
                        end
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    assign lk_result   = q_res;
    assign lk_slot     = q_slot;
    assign lk_pa       = q_pa;
    assign lk_flags    = q_flags;
    assign ut_va       = q_va;
    assign ut_asid_chk = q_chk;

    // ---------------- sub-blocks ----------------
    itlb4_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ar_wr),
        .wr_data (ar_sel_data),
        .wr_slot (ar_addr),
        .wr_val  (ar_wdata),
        .rf_en   (rf_en),
        .rf_slot (victim),
        .rf_ent  (rf_ent),
        .rd_slot (ar_addr),
        .rd_data (ar_sel_data),
        .rd_word (ar_rdata),
        .ents    (ents)
    );

    itlb4_cam u_cam (
        .ents     (ents),
        .va       (q_va),
        .asid     (q_asid),
        .asid_chk (q_chk),
        .hit_cnt  (hit_cnt),
        .hit_idx  (hit_idx)
    );

    itlb4_lru u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch_en),
        .touch_slot (touch_slot),
        .victim     (victim)
    );

    // ---------------- assertions ----------------
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done);

    // R5
    multi_norefill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && hit_cnt > CNT_W'(1)) |=> (!ut_req && lk_done && lk_result == RES_MULTI));

    // R6
    ut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ut_req && !ut_rsp_valid) |=> ut_req);

    // R7
    hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_result == RES_HIT) |-> ents[lk_slot].flags[F_VALID]);

    // R10
    busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_en && ar_we && lk_busy && !rf_en) |=> $stable(ents));

endmodule

// File: tb/itlb4_test.sv
module itlb4_test;
    import itlb4_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req = 0, lk_asid_chk = 0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_busy, lk_done, ut_req, ut_asid_chk;
    logic [1:0]  lk_result, lk_slot;
    logic [31:0] lk_pa, ut_va, ar_rdata;
    logic [8:0]  lk_flags;
    logic        ut_rsp_valid = 0;
    logic [1:0]  ut_rsp_kind = '0;
    logic [21:0] ut_rsp_vpn = '0;
    logic [7:0]  ut_rsp_asid = '0;
    logic [18:0] ut_rsp_ppn = '0;
    logic [8:0]  ut_rsp_flags = '0;
    logic        ar_en = 0, ar_we = 0, ar_sel_data = 0;
    logic [1:0]  ar_addr = '0;
    logic [31:0] ar_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    itlb4 uut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_asid(lk_asid),
        .lk_asid_chk(lk_asid_chk), .lk_busy(lk_busy), .lk_done(lk_done),
        .lk_result(lk_result), .lk_slot(lk_slot), .lk_pa(lk_pa), .lk_flags(lk_flags),
        .ut_req(ut_req), .ut_va(ut_va), .ut_asid_chk(ut_asid_chk),
        .ut_rsp_valid(ut_rsp_valid), .ut_rsp_kind(ut_rsp_kind), .ut_rsp_vpn(ut_rsp_vpn),
        .ut_rsp_asid(ut_rsp_asid), .ut_rsp_ppn(ut_rsp_ppn), .ut_rsp_flags(ut_rsp_flags),
        .ar_en(ar_en), .ar_we(ar_we), .ar_sel_data(ar_sel_data), .ar_addr(ar_addr),
        .ar_wdata(ar_wdata), .ar_rdata(ar_rdata)
    );

    // ---------------- reference model ----------------
    logic [21:0] m_vpn [4];
    logic [7:0]  m_asid[4];
    logic [18:0] m_ppn [4];
    logic [8:0]  m_flg [4];
    logic [5:0]  m_lru;

    function automatic logic [31:0] b_mask(input logic [8:0] f);
        case ({f[7], f[4]})
            2'b00:   return 32'hFFFFFC00;
            2'b01:   return 32'hFFFFF000;
            2'b10:   return 32'hFFFF0000;
            default: return 32'hFFF00000;
        endcase
    endfunction

    function automatic bit b_match(input int i, input logic [31:0] va,
                                   input logic [7:0] a, input bit c);
        return m_flg[i][8] && (!c || m_flg[i][1] || m_asid[i] == a) &&
               ((({m_vpn[i], 10'b0} ^ va) & b_mask(m_flg[i])) == 32'h0);
    endfunction

    function automatic logic [31:0] b_pa(input int i, input logic [31:0] va);
        logic [31:0] m;
        m = b_mask(m_flg[i]);
        return ({3'b0, m_ppn[i], 10'b0} & m) | (va & ~m);
    endfunction

    function automatic logic [5:0] b_touch(input logic [5:0] l, input int s);
        case (s)
            0:       return l & 6'h07;
            1:       return (l & 6'h19) | 6'h20;
            2:       return (l & 6'h3E) | 6'h14;
            default: return l | 6'h0B;
        endcase
    endfunction

    function automatic int b_victim(input logic [5:0] l);
        if ((l & 6'h38) == 6'h38) return 0;
        if ((l & 6'h26) == 6'h06) return 1;
        if ((l & 6'h15) == 6'h01) return 2;
        return 3;
    endfunction

    function automatic logic [21:0] rand_vpn();
        return {10'h000, 1'($urandom), 7'h00, 4'($urandom)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- array access ----------------
    task automatic arr_wr(input bit sel, input int slot, input logic [31:0] val);
        @(negedge clk);
        ar_en = 1; ar_we = 1; ar_sel_data = sel; ar_addr = 2'(slot); ar_wdata = val;
        @(negedge clk);
        ar_en = 0; ar_we = 0;
        if (!sel) begin
            m_vpn[slot] = val[31:10]; m_asid[slot] = val[7:0]; m_flg[slot][8] = val[8];
        end else begin
            m_ppn[slot] = val[28:10]; m_flg[slot] = val[8:0] & 9'h1DA;
        end
    endtask

    task automatic arr_check_all();
        logic [31:0] e;
        for (int s = 0; s < 4; s++) begin
            ar_addr = 2'(s); ar_sel_data = 0; #1;
            e = {m_vpn[s], 1'b0, m_flg[s][8], m_asid[s]};
            chk(ar_rdata == e, "R8", "address array read", ar_rdata, e);
            ar_sel_data = 1; #1;
            e = {3'b0, m_ppn[s], 1'b0, m_flg[s]};
            chk(ar_rdata == e, "R9", "data array read", ar_rdata, e);
        end
    endtask

    // ---------------- lookup with unified-buffer responder ----------------
    task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input bit c,
                          input logic [1:0] ukind, input logic [21:0] uvpn,
                          input logic [7:0] uasid, input logic [18:0] uppn,
                          input logic [8:0] uflg, input int delay);
        int n, idx, cnt, d, v;
        bit seen;
        logic [31:0] e;
        n = 0; idx = 0;
        for (int i = 0; i < 4; i++)
            if (b_match(i, va, asid, c)) begin
                if (n == 0) idx = i;
                n++;
            end
        @(negedge clk);
        lk_req = 1; lk_va = va; lk_asid = asid; lk_asid_chk = c;
        @(negedge clk);
        lk_req = 0;
        cnt = 0; seen = 0; d = delay;
        while (!lk_done && cnt < 64) begin
            @(negedge clk);
            cnt++;
            if (ut_req && !lk_done) begin
                if (!seen) chk(ut_va == va, "R6", "refill address", ut_va, va);
                seen = 1;
                if (d == 0) begin
                    ut_rsp_valid = 1; ut_rsp_kind = ukind; ut_rsp_vpn = uvpn;
                    ut_rsp_asid = uasid; ut_rsp_ppn = uppn; ut_rsp_flags = uflg;
                end else d--;
            end
        end
        ut_rsp_valid = 0;
        chk(lk_done, "R11", "lookup completes", 32'(lk_done), 1);
        if (n == 1) begin
            chk(cnt == 1 && !seen, "R11", "hit latency", 32'(cnt), 1);
            chk(lk_result == RES_HIT, "R2", "hit result", 32'(lk_result), 1);
            chk(lk_slot == 2'(idx), "R2", "hit slot", 32'(lk_slot), 32'(idx));
            e = b_pa(idx, va);
            chk(lk_pa == e, "R2", "physical address", lk_pa, e);
            chk(lk_flags == m_flg[idx], "R2", "hit flags", 32'(lk_flags), 32'(m_flg[idx]));
            m_lru = b_touch(m_lru, idx);
        end else if (n > 1) begin
            chk(cnt == 1 && !seen, "R5", "multi-hit without refill", 32'(cnt), 1);
            chk(lk_result == RES_MULTI, "R5", "multi-hit result", 32'(lk_result), 3);
        end else begin
            chk(seen, "R6", "refill requested on miss", 32'(seen), 1);
            if (ukind == RES_HIT) begin
                v = b_victim(m_lru);
                m_vpn[v] = uvpn; m_asid[v] = uasid; m_ppn[v] = uppn;
                m_flg[v] = uflg & 9'h1DA;
                m_lru = b_touch(m_lru, v);
                chk(lk_result == RES_HIT, "R7", "refill result", 32'(lk_result), 1);
                chk(lk_slot == 2'(v), "R7", "victim slot", 32'(lk_slot), 32'(v));
                e = b_pa(v, va);
                chk(lk_pa == e, "R7", "refill physical address", lk_pa, e);
                chk(lk_flags == m_flg[v], "R7", "masked flags", 32'(lk_flags), 32'(m_flg[v]));
            end else begin
                chk(lk_result == ukind, "R6", "passed-on result", 32'(lk_result), 32'(ukind));
            end
        end
        @(negedge clk);
        chk(!lk_done && !lk_busy, "R11", "done pulse ends", 32'({lk_done, lk_busy}), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0417);
        for (int i = 0; i < 4; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0; m_flg[i] = '0;
        end
        m_lru = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(!lk_done && !lk_busy && !ut_req, "R1", "idle after reset",
            32'({lk_done, lk_busy, ut_req}), 0);
        arr_check_all();

        // R6 miss and multi passed on from unified buffer
        lookup(32'h0000_1234, 8'd1, 1, RES_MISS, '0, '0, '0, '0, 0);
        lookup(32'h0000_1234, 8'd1, 1, RES_MULTI, '0, '0, '0, '0, 2);
        arr_check_all();

        // R7 fill from reset: victims 3,2,1,0; flags masked
        for (int k = 1; k <= 4; k++)
            lookup({22'(k * 16), 10'h055}, 8'd3, 1, RES_HIT, 22'(k * 16), 8'd3,
                   19'(k * 256 + 7), 9'h16F, k % 3);
        chk(m_flg[3] == 9'h14A, "R7", "flag mask on refill", 32'(m_flg[3]), 32'h14A);
        arr_check_all();

        // R4 hits reorder the recency, then a refill lands on the chosen victim
        lookup({22'd32, 10'h001}, 8'd3, 1, RES_MISS, '0, '0, '0, '0, 0);
        lookup({22'd48, 10'h3FF}, 8'd3, 1, RES_MISS, '0, '0, '0, '0, 0);
        lookup({22'd999, 10'h0}, 8'd3, 1, RES_HIT, 22'd999, 8'd3, 19'h7ABC, 9'h100, 1);

        // R3 identifier rules
        for (int s = 0; s < 4; s++) arr_wr(0, s, 32'h0);
        arr_wr(1, 0, {3'b0, 19'h1234, 1'b0, 9'h100});
        arr_wr(0, 0, {22'h55, 1'b0, 1'b1, 8'd5});
        lookup({22'h55, 10'h10}, 8'd6, 1, RES_MISS, '0, '0, '0, '0, 0);
        lookup({22'h55, 10'h10}, 8'd6, 0, RES_MISS, '0, '0, '0, '0, 0);
        lookup({22'h55, 10'h10}, 8'd5, 1, RES_MISS, '0, '0, '0, '0, 0);
        arr_wr(1, 0, {3'b0, 19'h1234, 1'b0, 9'h102});
        lookup({22'h55, 10'h10}, 8'd6, 1, RES_MISS, '0, '0, '0, '0, 0);

        // R2 page sizes: offsets inside and outside each page
        for (int sz = 0; sz < 4; sz++) begin
            arr_wr(0, 0, 32'h0);
            arr_wr(1, 1, {3'b0, 19'h5A5A5, 1'b0, 1'b1, sz[1], 2'b00, sz[0], 4'b0000});
            arr_wr(0, 1, {22'hC00, 1'b0, 1'b1, 8'd1});
            lookup({22'hC00 | 22'(sz * 3), 10'h2B7}, 8'd1, 1, RES_MISS, '0, '0, '0, '0, 0);
            lookup({22'hC00 | 22'h3FF, 10'h3}, 8'd1, 1, RES_MISS, '0, '0, '0, '0, 1);
        end

        // R5 two entries on the same page
        arr_wr(1, 2, {3'b0, 19'h00111, 1'b0, 9'h100});
        arr_wr(0, 2, {22'h77, 1'b0, 1'b1, 8'd1});
        arr_wr(1, 3, {3'b0, 19'h00222, 1'b0, 9'h102});
        arr_wr(0, 3, {22'h77, 1'b0, 1'b1, 8'd2});
        lookup({22'h77, 10'h0}, 8'd1, 1, RES_HIT, 22'h1, 8'd1, 19'h1, 9'h100, 0);
        arr_check_all();

        // R10 writes during a lookup are dropped
        @(negedge clk);
        lk_req = 1; lk_va = 32'hFFFF_FC00; lk_asid = 8'd9; lk_asid_chk = 1;
        @(negedge clk);
        lk_req = 0;
        ar_en = 1; ar_we = 1; ar_sel_data = 0; ar_addr = 2'd2; ar_wdata = 32'hDEAD_B1FF;
        @(negedge clk);
        chk(ut_req, "R10", "busy in refill", 32'(ut_req), 1);
        ar_addr = 2'd3;
        ut_rsp_valid = 1; ut_rsp_kind = RES_MISS;
        @(negedge clk);
        ut_rsp_valid = 0; ar_en = 0; ar_we = 0;
        chk(lk_done && lk_result == RES_MISS, "R10", "lookup finished",
            32'(lk_result), 2);
        @(negedge clk);
        arr_check_all();

        // constrained random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 3) begin
                arr_wr(0, int'($urandom % 4),
                       {rand_vpn(), 1'b0, 1'(($urandom % 4) != 0), 8'(1 + $urandom % 2)});
            end else if (op < 5) begin
                arr_wr(1, int'($urandom % 4),
                       {3'b0, 19'($urandom), 1'b0, 9'($urandom)});
            end else if (op < 9) begin
                logic [1:0] k;
                k = (($urandom % 10) < 6) ? RES_HIT : ((($urandom % 2) == 0) ? RES_MISS : RES_MULTI);
                lookup({rand_vpn(), 10'($urandom)}, 8'(1 + $urandom % 2), 1'($urandom),
                       k, rand_vpn(), 8'(1 + $urandom % 2), 19'($urandom),
                       9'($urandom) | 9'h100, int'($urandom % 4));
            end else begin
                @(negedge clk);
                arr_check_all();
            end
        end
        @(negedge clk);
        arr_check_all();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule